// File: doc/BRIEF.md
# Effective Address Generator

This unit turns an addressing-mode code, up to two operand bytes and the two index registers of an 8-bit processor into a 16-bit effective address. The plain modes are page zero, absolute, and their X or Y indexed forms. These are combinational sums, and their result is registered one cycle after the request. The indirect modes first fetch a two-byte pointer from memory. The unit issues two back-to-back reads on a byte-wide bus and forms the address once the second byte has returned. Bytes are little-endian: the lower address holds the low byte.

The caller raises `start` for one cycle with the mode and operands present. The result comes back as a one-cycle `ea_valid` pulse. While `busy` is high the unit ignores new requests. The read bus has a fixed latency of one cycle: data for a read issued in cycle k is present on `mem_rdata` in cycle k+1. Modes that have no memory operand (immediate, implied, accumulator, relative, bit-test-and-branch) still return a pulse, but with `ea_none` set.

Top module: `eff_addr_unit`

## Requirements
- R1: After reset, `ea_valid`, `mem_rd` and `busy` are 0 and `ea` is 0x0000.
- R2: Mode 1 gives {0x00, op_lo}. Mode 2 gives {0x00, (op_lo+idx_x) mod 256} and mode 3 gives {0x00, (op_lo+idx_y) mod 256}. Each returns `ea_valid` one cycle after `start` and issues no read.
- R3: Mode 4 gives {op_hi, op_lo}. Modes 5 and 6 add idx_x or idx_y to {op_hi, op_lo} modulo 0x10000. Each returns in one cycle and issues no read.
- R4: Mode 0 and the unused codes 12 to 15 return `ea_valid` after one cycle with `ea_none`=1 and `ea`=0x0000, and issue no read. Every other mode returns `ea_none`=0.
- R5: Mode 7 (page-zero indexed indirect) reads the low byte at p=(op_lo+idx_x) mod 256, then the high byte at (p+1) mod 256, both in page zero. The result is {high, low}.
- R6: Mode 8 (page-zero indirect post-indexed) reads at op_lo and (op_lo+1) mod 256, then adds idx_y to the pointer modulo 0x10000.
- R7: Mode 9 (page-zero indirect) reads at op_lo and (op_lo+1) mod 256 and returns the pointer unchanged.
- R8: Mode 10 (absolute indirect) reads at {op_hi, op_lo} and at that address plus one modulo 0x10000.
- R9: Mode 11 (absolute indexed indirect) reads at q=({op_hi, op_lo}+idx_x) mod 0x10000, then at (q+1) mod 0x10000.
- R10: An indirect request drives `mem_rd` high for exactly two consecutive cycles, starting in the cycle after `start`, with the low-byte address first. `ea_valid` rises two cycles after the last read cycle, which is four cycles after `start`.
- R11: `mem_rd` is 0 whenever the unit is idle and for every mode that needs no pointer.
- R12: A `start` that arrives while `busy` is 1 is ignored. The request in flight finishes with the operands captured at its own start.
- R13: `ea_valid` is high for one cycle only. `ea` and `ea_none` hold their values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, accepted when not busy |
| mode | input | 4 | Addressing-mode code (see requirements) |
| op_lo | input | 8 | First operand byte (address low byte) |
| op_hi | input | 8 | Second operand byte (address high byte) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| busy | output | 1 | Indirect request in progress |
| mem_rd | output | 1 | Pointer-byte read strobe |
| mem_addr | output | 16 | Pointer-byte read address |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| ea_valid | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address |
| ea_none | output | 1 | Mode has no effective address |

## Verification
The sweeps walk every operand low byte through each mode, with index values and high bytes chosen so that page-zero sums pass 0xFF. Pointer fetches are aimed at 0x00FF and 0xFFFF. A unit that carried an index sum into the high byte would return 0x01xx for a page-zero mode. A unit that fetched the second pointer byte at 0x0100 would read the wrong high byte, and its read-address log would not match. Post-indexed sums that cross 0xFFFF catch a dropped wrap. A second `start` with changed operands during an indirect fetch catches a unit that accepts new requests while busy. Read counts and cycle-exact latency catch a sequencer that skips or repeats a read.

// File: rtl/eau_pkg.sv
package eau_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;
  localparam int MODE_W = 4;
  localparam int HI_W   = ADDR_W - BYTE_W;

  typedef enum logic [MODE_W-1:0] {
    AM_NONE = 4'd0,
    AM_PZ   = 4'd1,
    AM_PZX  = 4'd2,
    AM_PZY  = 4'd3,
    AM_AB   = 4'd4,
    AM_ABX  = 4'd5,
    AM_ABY  = 4'd6,
    AM_PZXI = 4'd7,
    AM_PZIY = 4'd8,
    AM_PZI  = 4'd9,
    AM_ABI  = 4'd10,
    AM_ABXI = 4'd11
  } amode_e;

  // index sum that stays in page zero
  function automatic logic [BYTE_W-1:0] page_sum(input logic [BYTE_W-1:0] b,
                                                 input logic [BYTE_W-1:0] i);
    return b + i;
  endfunction

  // full-width index sum, wraps at the top of the address space
  function automatic logic [ADDR_W-1:0] wide_sum(input logic [ADDR_W-1:0] a,
                                                 input logic [BYTE_W-1:0] i);
    return a + ADDR_W'(i);
  endfunction

  function automatic logic [ADDR_W-1:0] in_page0(input logic [BYTE_W-1:0] b);
    return {{HI_W{1'b0}}, b};
  endfunction

  // address of the second pointer byte
  function automatic logic [ADDR_W-1:0] next_ptr(input logic [ADDR_W-1:0] a,
                                                 input logic zp);
    logic [BYTE_W-1:0] low_nxt;
    low_nxt = a[BYTE_W-1:0] + BYTE_W'(1);
    return zp ? in_page0(low_nxt) : a + ADDR_W'(1);
  endfunction
endpackage

// File: rtl/eau_decode.sv
module eau_decode
  import eau_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [BYTE_W-1:0] op_lo,
  input  logic [BYTE_W-1:0] op_hi,
  input  logic [BYTE_W-1:0] idx_x,
  input  logic [BYTE_W-1:0] idx_y,
  output logic              is_none,
  output logic              is_ind,
  output logic [ADDR_W-1:0] direct_ea,
  output logic [ADDR_W-1:0] ptr_base,
  output logic              ptr_zp,
  output logic [BYTE_W-1:0] post_idx
);
  logic [ADDR_W-1:0] word_op;
  assign word_op = {op_hi, op_lo};

  always_comb begin
    is_none   = 1'b0;
    is_ind    = 1'b0;
    direct_ea = '0;
    ptr_base  = '0;
    ptr_zp    = 1'b0;
    post_idx  = '0;
    case (amode_e'(mode))
      AM_PZ:   direct_ea = in_page0(op_lo);
      AM_PZX:  direct_ea = in_page0(page_sum(op_lo, idx_x));
      AM_PZY:  direct_ea = in_page0(page_sum(op_lo, idx_y));
      AM_AB:   direct_ea = word_op;
      AM_ABX:  direct_ea = wide_sum(word_op, idx_x);
      AM_ABY:  direct_ea = wide_sum(word_op, idx_y);
      AM_PZXI: begin
        is_ind   = 1'b1;
        ptr_zp   = 1'b1;
        ptr_base = in_page0(page_sum(op_lo, idx_x));
      end
      AM_PZIY: begin
        is_ind   = 1'b1;
        ptr_zp   = 1'b1;
        ptr_base = in_page0(op_lo);
        post_idx = idx_y;
      end
      AM_PZI: begin
        is_ind   = 1'b1;
        ptr_zp   = 1'b1;
        ptr_base = in_page0(op_lo);
      end
      AM_ABI: begin
        is_ind   = 1'b1;
        ptr_base = word_op;
      end
      AM_ABXI: begin
        is_ind   = 1'b1;
        ptr_base = wide_sum(word_op, idx_x);
      end
      default: is_none = 1'b1;
    endcase
  end
endmodule

// File: rtl/eau_ptr_fsm.sv
module eau_ptr_fsm
  import eau_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] base,
  input  logic              zp_wrap,
  input  logic [BYTE_W-1:0] rdata,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] lo_byte,
  output logic              done,
  output logic              busy,
  output logic              zp_walk
);
  typedef enum logic [1:0] {PS_IDLE, PS_RLO, PS_RHI, PS_CAP} pstate_e;

  pstate_e           st_q;
  logic [ADDR_W-1:0] base_q;
  logic              zp_q;
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      base_q <= '0;
      zp_q   <= 1'b0;
      lo_q   <= '0;
    end else begin
      case (st_q)
        PS_IDLE: if (launch) begin
          base_q <= base;
          zp_q   <= zp_wrap;
          st_q   <= PS_RLO;
        end
        PS_RLO: st_q <= PS_RHI;
        PS_RHI: begin
          lo_q <= rdata;
          st_q <= PS_CAP;
        end
        default: st_q <= PS_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_en   = 1'b0;
    rd_addr = '0;
    if (st_q == PS_RLO) begin
      rd_en   = 1'b1;
      rd_addr = base_q;
    end else if (st_q == PS_RHI) begin
      rd_en   = 1'b1;
      rd_addr = next_ptr(base_q, zp_q);
    end
  end

  assign lo_byte = lo_q;
  assign done    = (st_q == PS_CAP);
  assign busy    = (st_q != PS_IDLE);
  assign zp_walk = zp_q & busy;
endmodule

// File: rtl/eau_combine.sv
module eau_combine
  import eau_pkg::*;
(
  input  logic [BYTE_W-1:0] ptr_hi,
  input  logic [BYTE_W-1:0] ptr_lo,
  input  logic [BYTE_W-1:0] idx,
  output logic [ADDR_W-1:0] addr
);
  assign addr = wide_sum({ptr_hi, ptr_lo}, idx);
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eau_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [BYTE_W-1:0] op_lo,
  input  logic [BYTE_W-1:0] op_hi,
  input  logic [BYTE_W-1:0] idx_x,
  input  logic [BYTE_W-1:0] idx_y,
  output logic              busy,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea,
  output logic              ea_none
);
  logic              dec_none, dec_ind, dec_zp;
  logic [ADDR_W-1:0] dec_ea, dec_base;
  logic [BYTE_W-1:0] dec_post;
  logic              take, take_ind, take_direct;
  logic              fsm_done, fsm_busy, zp_walk;
  logic [BYTE_W-1:0] fsm_lo;
  logic [BYTE_W-1:0] post_q;
  logic [ADDR_W-1:0] ind_ea;
  logic              valid_q, none_q;
  logic [ADDR_W-1:0] ea_q;

  eau_decode u_dec (
    .mode(mode), .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y),
    .is_none(dec_none), .is_ind(dec_ind), .direct_ea(dec_ea),
    .ptr_base(dec_base), .ptr_zp(dec_zp), .post_idx(dec_post)
  );

  assign take        = start & ~fsm_busy;
  assign take_ind    = take & dec_ind;
  assign take_direct = take & ~dec_ind;

  eau_ptr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .launch(take_ind), .base(dec_base),
    .zp_wrap(dec_zp), .rdata(mem_rdata), .rd_en(mem_rd), .rd_addr(mem_addr),
    .lo_byte(fsm_lo), .done(fsm_done), .busy(fsm_busy), .zp_walk(zp_walk)
  );

  eau_combine u_cmb (
    .ptr_hi(mem_rdata), .ptr_lo(fsm_lo), .idx(post_q), .addr(ind_ea)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_q  <= '0;
      valid_q <= 1'b0;
      none_q  <= 1'b0;
      ea_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      if (take_ind) post_q <= dec_post;
      if (take_direct) begin
        valid_q <= 1'b1;
        none_q  <= dec_none;
        ea_q    <= dec_ea;
      end else if (fsm_done) begin
        valid_q <= 1'b1;
        none_q  <= 1'b0;
        ea_q    <= ind_ea;
      end
    end
  end

  assign busy     = fsm_busy;
  assign ea_valid = valid_q;
  assign ea       = ea_q;
  assign ea_none  = none_q;
endmodule

// File: rtl/eff_addr_unit_chk.sv
module eff_addr_unit_chk
  import eau_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ea_valid,
  input logic [ADDR_W-1:0] ea,
  input logic              take_direct,
  input logic              zp_walk
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!ea_valid && !mem_rd && !busy && ea == '0)); // R1
  AST_DIRECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_direct |=> (ea_valid && !mem_rd)); // R2
  AST_ZP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && zp_walk) |-> (mem_addr[ADDR_W-1:BYTE_W] == '0)); // R5
  AST_READ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |=> mem_rd); // R10
  AST_READ_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |=> !mem_rd); // R10
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd) |=> ea_valid); // R10
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd); // R11
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |=> !ea_valid); // R13
  AST_EA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ea_valid |-> $stable(ea)); // R13
endmodule

bind eff_addr_unit eff_addr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd(mem_rd),
  .mem_addr(mem_addr), .ea_valid(ea_valid), .ea(ea),
  .take_direct(take_direct), .zp_walk(zp_walk)
);

// File: tb/eff_addr_unit_bench.sv
module eff_addr_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0;
  logic        busy, mem_rd, ea_valid, ea_none;
  logic [15:0] mem_addr, ea;
  logic [7:0]  mem_rdata = '0;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eff_addr_unit u_eff_addr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op_lo(op_lo),
    .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y), .busy(busy),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .ea_valid(ea_valid), .ea(ea), .ea_none(ea_none)
  );

  // memory content depends only on the address
  function automatic int memf(input int a);
    return ((a % 256) ^ ((a / 256) * 5) ^ 8'hA5) % 256;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= 8'(memf(int'(mem_addr)));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    summary_and_end();
  end

  task automatic run_op(input int m, input int l, input int h, input int xv,
                        input int yv, input string req, input bit disturb);
    int exp_ea, p0, p1, nrd, lat, hold_ea;
    bit ind, none;
    int ra [2];
    ind = 1'b0;
    none = 1'b0;
    p0 = 0;
    p1 = 0;
    exp_ea = 0;
    case (m)
      1: exp_ea = l;
      2: exp_ea = (l + xv) % 256;
      3: exp_ea = (l + yv) % 256;
      4: exp_ea = h * 256 + l;
      5: exp_ea = (h * 256 + l + xv) % 65536;
      6: exp_ea = (h * 256 + l + yv) % 65536;
      7: begin ind = 1; p0 = (l + xv) % 256; p1 = (p0 + 1) % 256; end
      8, 9: begin ind = 1; p0 = l; p1 = (l + 1) % 256; end
      10: begin ind = 1; p0 = h * 256 + l; p1 = (p0 + 1) % 65536; end
      11: begin ind = 1; p0 = (h * 256 + l + xv) % 65536; p1 = (p0 + 1) % 65536; end
      default: none = 1;
    endcase
    if (ind) begin
      exp_ea = memf(p1) * 256 + memf(p0);
      if (m == 8) exp_ea = (exp_ea + yv) % 65536;
    end
    @(negedge clk);
    mode = 4'(m); op_lo = 8'(l); op_hi = 8'(h); idx_x = 8'(xv); idx_y = 8'(yv);
    start = 1'b1;
    @(negedge clk);
    start = disturb;
    if (disturb) begin
      mode = 4'd4; op_lo = ~op_lo; op_hi = ~op_hi; idx_x = ~idx_x; idx_y = ~idx_y;
    end
    nrd = 0;
    lat = 1;
    ra[0] = -1;
    ra[1] = -1;
    for (int c = 0; c < 8; c++) begin
      if (mem_rd) begin
        if (nrd < 2) ra[nrd] = int'(mem_addr);
        nrd++;
      end
      if (ea_valid) break;
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    start = 1'b0;
    check(ea_valid == 1'b1 && int'(ea) == exp_ea, req, int'(ea), exp_ea);
    check(ea_none == none, {req, " R4 none flag"}, int'(ea_none), int'(none));
    check(lat == (ind ? 4 : 1), {req, " R10 latency"}, lat, ind ? 4 : 1);
    check(nrd == (ind ? 2 : 0), {req, " R11 read count"}, nrd, ind ? 2 : 0);
    if (ind) begin
      check(ra[0] == p0, {req, " first pointer address"}, ra[0], p0);
      check(ra[1] == p1, {req, " second pointer address"}, ra[1], p1);
    end
    hold_ea = int'(ea);
    @(negedge clk);
    check(ea_valid == 1'b0 && int'(ea) == hold_ea, {req, " R13 pulse/hold"},
          int'(ea), hold_ea);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ea_valid == 1'b0 && mem_rd == 1'b0 && busy == 1'b0 && ea == 16'h0,
          "R1 reset state", int'(ea), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ea_valid == 1'b0 && mem_rd == 1'b0 && busy == 1'b0,
          "R1 idle after reset", int'({ea_valid, mem_rd, busy}), 0);

    // corner cases
    run_op(2, 8'hFF, 0, 1, 0, "R2 page-zero X wrap", 1'b0);
    run_op(3, 8'h80, 0, 0, 8'h80, "R2 page-zero Y wrap", 1'b0);
    run_op(5, 8'hFF, 8'hFF, 1, 0, "R3 absolute X wrap", 1'b0);
    run_op(6, 8'hF0, 8'hFF, 0, 8'h20, "R3 absolute Y wrap", 1'b0);
    run_op(7, 8'hFE, 0, 1, 0, "R5 indexed pointer at 00FF", 1'b0);
    run_op(7, 8'h10, 0, 8'hF0, 0, "R5 index sum wraps to 0000", 1'b0);
    run_op(8, 8'hFF, 0, 0, 8'hFF, "R6 pointer at 00FF post index", 1'b0);
    run_op(9, 8'hFF, 0, 0, 0, "R7 pointer at 00FF", 1'b0);
    run_op(10, 8'hFF, 8'hFF, 0, 0, "R8 pointer at FFFF", 1'b0);
    run_op(11, 8'hFE, 8'hFF, 1, 0, "R9 pointer at FFFF", 1'b0);
    run_op(0, 8'h12, 8'h34, 5, 6, "R4 no-address mode", 1'b0);
    for (int m = 12; m < 16; m++) run_op(m, 8'h55, 8'hAA, 1, 2, "R4 unused code", 1'b0);
    // request during busy
    run_op(7, 8'h20, 0, 3, 0, "R12 start while busy", 1'b1);
    run_op(10, 8'h34, 8'h12, 0, 0, "R12 start while busy abs", 1'b1);

    // sweeps over every operand low byte
    for (int l = 0; l < 256; l++) begin
      int xv, yv, h;
      xv = (l * 7 + 3) % 256;
      yv = (255 - l) * 5 % 256;
      h  = (l ^ 8'hC3) % 256;
      run_op(1, l, h, xv, yv, "R2 sweep page zero", 1'b0);
      run_op(2, l, h, xv, yv, "R2 sweep page zero X", 1'b0);
      run_op(3, l, h, xv, yv, "R2 sweep page zero Y", 1'b0);
      run_op(4, l, h, xv, yv, "R3 sweep absolute", 1'b0);
      run_op(5, l, h, xv, yv, "R3 sweep absolute X", 1'b0);
      run_op(6, l, h, xv, yv, "R3 sweep absolute Y", 1'b0);
      run_op(7, l, h, xv, yv, "R5 sweep", 1'b0);
      run_op(8, l, h, xv, yv, "R6 sweep", 1'b0);
      run_op(9, l, h, xv, yv, "R7 sweep", 1'b0);
      run_op(10, l, h, xv, yv, "R8 sweep", 1'b0);
      run_op(11, l, h, xv, yv, "R9 sweep", 1'b0);
    end
    summary_and_end();
  end
endmodule